// File: doc/BRIEF.md
# SPI-Mode Card Single-Block Write Receiver

This block is the byte-level control for the card end of a memory card running in SPI mode, covering the data phase of a single-block write. The serial shifter outside it delivers each received byte with a one-cycle valid strobe. After that exchange the block presents the byte it wants shifted out on the next exchange. In command mode the block sorts incoming bytes into three kinds. A filler byte is ignored. A start token opens a data block. Any other byte is a command opener, and the block keeps its index and then lets the argument bytes go past.

Once the start token arrives, payload bytes go to a storage write port that has a ready input, and each byte is echoed back to the host. The payload ends after a full block, or at once when storage stops accepting bytes. The two checksum bytes that follow are consumed without any check. The host then reads back a one-byte "data accepted" response, and the block returns to command mode. The block length and the number of bytes taken by a command are parameters.

Top module: `sdw_card_rx`

## Requirements
- R1: After a synchronous reset the phase is command (code 0), the outgoing byte is 0xFF, the write strobe is low and the command index is 0.
- R2: In command mode a received 0xFF produces the answer 0xFF and the block stays in command mode.
- R3: In command mode a received 0xFE (start token) produces the answer 0xFF and moves the block to the data-write phase (code 2).
- R4: In command mode any other byte produces the answer 0xFF, latches its low six bits as the command index and moves to the argument phase (code 1). The argument phase consumes ARG_LEN bytes, answering 0xFF to each, and then returns to command mode.
- R5: In the data-write phase every valid byte received while storage is ready appears on the write data port, together with a write strobe that lasts one cycle, in the cycle after it was received. The same byte is also the answer.
- R6: After BLOCK_LEN payload bytes the block enters the checksum-skip phase (code 3).
- R7: A payload byte that arrives while storage is not ready is not written. It is still echoed back, and it ends the payload at once by moving the block to the checksum-skip phase.
- R8: The checksum-skip phase consumes exactly two bytes and answers 0xFF to each. After the second byte the block is in the response phase (code 4), and the write byte count is cleared so that the next block can run to its full length.
- R9: In the response phase the next exchange is answered with 0x05, and the block returns to command mode.
- R10: When no valid byte arrives, the phase, the answer and the command index hold their values and the write strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Byte to shift out on the next exchange |
| phase | output | 3 | Current phase: 0 command, 1 argument, 2 write, 3 checksum skip, 4 response |
| cmd_index | output | 6 | Index of the last command opener |
| st_ready | input | 1 | Storage can accept a byte |
| st_wr_en | output | 1 | One-cycle storage write strobe |
| st_wr_data | output | 8 | Byte to be written to storage |

## Verification
Two end conditions can fall on the same byte: the block-length limit is reached, and storage drops ready on that very byte. The bench runs the payload with ready withdrawn at every position from the first byte to the last, plus one run where ready never drops. This includes the case where the withdrawal lands on the final byte. Each run is judged by the number of strobed bytes, by the absence of a strobe on the refused byte, by the switch to the checksum-skip phase on exactly that byte, and by a full-length block afterwards, which shows that the count was cleared.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam logic [7:0] BYTE_FILL  = 8'hFF;
    localparam logic [7:0] BYTE_START = 8'hFE;
    localparam logic [7:0] BYTE_OK    = 8'h05;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ARG   = 3'd1,
        PH_WRITE = 3'd2,
        PH_SKIP  = 3'd3,
        PH_RESP  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        K_FILL  = 2'd0,
        K_START = 2'd1,
        K_OPEN  = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        phase_e     nxt;
        logic [7:0] ans;
    } step_t;

    function automatic cmd_kind_e classify(input logic [7:0] b);
        if (b == BYTE_FILL)       return K_FILL;
        else if (b == BYTE_START) return K_START;
        else                      return K_OPEN;
    endfunction

endpackage

// File: rtl/sdw_count.sv
module sdw_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (inc)   q <= q + 1'b1;
    end
endmodule

// File: rtl/sdw_store_port.sv
module sdw_store_port (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] din,
    output logic       wr_en,
    output logic [7:0] wr_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= go;
            if (go) wr_data <= din;
        end
    end
endmodule

// File: rtl/sdw_resp_buf.sv
module sdw_resp_buf (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] din,
    output logic [7:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/sdw_card_rx.sv
module sdw_card_rx
    import sdw_pkg::*;
#(
    parameter int BLOCK_LEN = 512,
    parameter int ARG_LEN   = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic [7:0] tx_byte,
    output logic [2:0] phase,
    output logic [5:0] cmd_index,
    input  logic       st_ready,
    output logic       st_wr_en,
    output logic [7:0] st_wr_data
);
    localparam int CNT_W = $clog2(BLOCK_LEN + 1);
    localparam int ARG_W = $clog2(ARG_LEN + 1);
    localparam logic [CNT_W-1:0] WC_LAST = CNT_W'(BLOCK_LEN - 1);
    localparam logic [ARG_W-1:0] AG_LAST = ARG_W'(ARG_LEN - 1);

    phase_e           ph_q;
    logic [7:0]       tx_q;
    logic [5:0]       idx_q;
    step_t            st;
    logic             wc_clr, wc_inc, sk_clr, sk_inc, ag_clr, ag_inc;
    logic             idx_load, resp_load, wr_go;
    logic [CNT_W-1:0] wc_q;
    logic [1:0]       sk_q;
    logic [ARG_W-1:0] ag_q;
    logic [7:0]       resp_q;

    sdw_count #(.W(CNT_W)) u_wcnt (.clk(clk), .rst(rst), .clr(wc_clr), .inc(wc_inc), .q(wc_q));
    sdw_count #(.W(2))     u_skip (.clk(clk), .rst(rst), .clr(sk_clr), .inc(sk_inc), .q(sk_q));
    sdw_count #(.W(ARG_W)) u_arg  (.clk(clk), .rst(rst), .clr(ag_clr), .inc(ag_inc), .q(ag_q));

    sdw_resp_buf u_resp (.clk(clk), .rst(rst), .load(resp_load), .din(BYTE_OK), .q(resp_q));

    sdw_store_port u_store (
        .clk(clk), .rst(rst), .go(wr_go), .din(rx_byte),
        .wr_en(st_wr_en), .wr_data(st_wr_data)
    );

    always_comb begin
        st.nxt    = ph_q;
        st.ans    = tx_q;
        wc_clr    = 1'b0;
        wc_inc    = 1'b0;
        sk_clr    = 1'b0;
        sk_inc    = 1'b0;
        ag_clr    = 1'b0;
        ag_inc    = 1'b0;
        idx_load  = 1'b0;
        resp_load = 1'b0;
        wr_go     = 1'b0;
        if (rx_valid) begin
            unique case (ph_q)
                PH_CMD: begin
                    st.ans = BYTE_FILL;
                    unique case (classify(rx_byte))
                        K_FILL:  st.nxt = PH_CMD;
                        K_START: begin
                            st.nxt = PH_WRITE;
                            wc_clr = 1'b1;
                        end
                        default: begin
                            st.nxt   = PH_ARG;
                            idx_load = 1'b1;
                            ag_clr   = 1'b1;
                        end
                    endcase
                end
                PH_ARG: begin
                    st.ans = BYTE_FILL;
                    if (ag_q == AG_LAST) begin
                        st.nxt = PH_CMD;
                        ag_clr = 1'b1;
                    end else begin
                        ag_inc = 1'b1;
                    end
                end
                PH_WRITE: begin
                    st.ans = rx_byte;
                    wr_go  = st_ready;
                    wc_inc = 1'b1;
                    if (!st_ready || wc_q == WC_LAST) begin
                        st.nxt = PH_SKIP;
                        sk_clr = 1'b1;
                    end
                end
                PH_SKIP: begin
                    st.ans = BYTE_FILL;
                    if (sk_q == 2'd1) begin
                        st.nxt    = PH_RESP;
                        resp_load = 1'b1;
                        wc_clr    = 1'b1;
                        sk_clr    = 1'b1;
                    end else begin
                        sk_inc = 1'b1;
                    end
                end
                PH_RESP: begin
                    st.ans = resp_q;
                    st.nxt = PH_CMD;
                end
                default: begin
                    st.ans = BYTE_FILL;
                    st.nxt = PH_CMD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_CMD;
            tx_q  <= BYTE_FILL;
            idx_q <= '0;
        end else begin
            ph_q <= st.nxt;
            tx_q <= st.ans;
            if (idx_load) idx_q <= rx_byte[5:0];
        end
    end

    assign tx_byte   = tx_q;
    assign phase     = ph_q;
    assign cmd_index = idx_q;

    AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        st_wr_en |-> $past(ph_q == PH_WRITE && rx_valid && st_ready)); // R5
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        wc_q <= CNT_W'(BLOCK_LEN)); // R6
    AST_REFUSED_ENDS: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_WRITE && rx_valid && !st_ready) |=> (ph_q == PH_SKIP && !st_wr_en)); // R7
    AST_SKIP_TO_RESP: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_SKIP && rx_valid && sk_q == 2'd1) |=> (ph_q == PH_RESP && tx_q == BYTE_FILL)); // R8
    AST_RESP_ANSWER: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_RESP && rx_valid) |=> (ph_q == PH_CMD && tx_q == BYTE_OK)); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> ($stable(ph_q) && $stable(tx_q) && !st_wr_en)); // R10
endmodule

// File: tb/sdw_card_rx_test.sv
module sdw_card_rx_test;
    localparam int BL = 8;
    localparam int AL = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       st_ready = 1'b1;
    logic [7:0] tx_byte, st_wr_data;
    logic [2:0] phase;
    logic [5:0] cmd_index;
    logic       st_wr_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdw_card_rx #(.BLOCK_LEN(BL), .ARG_LEN(AL)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_byte), .phase(phase), .cmd_index(cmd_index),
        .st_ready(st_ready), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one exchange; outputs are sampled one cycle after the byte is taken
    task automatic xfer(input logic [7:0] b, input logic rdy);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        st_ready = rdy;
        @(negedge clk);
        rx_valid = 1'b0;
        st_ready = 1'b1;
    endtask

    task automatic tail();
        xfer(8'h11, 1'b1);
        chk("R8 crc1 ans", tx_byte, 8'hFF); chk("R8 crc1 phase", phase, 3);
        xfer(8'h22, 1'b1);
        chk("R8 crc2 ans", tx_byte, 8'hFF); chk("R8 crc2 phase", phase, 4);
        xfer(8'hFF, 1'b1);
        chk("R9 resp ans", tx_byte, 8'h05); chk("R9 back to cmd", phase, 0);
    endtask

    task automatic block(input int drop);
        int n_wr;
        n_wr = 0;
        xfer(8'hFE, 1'b1);
        chk("R3 token ans", tx_byte, 8'hFF); chk("R3 token phase", phase, 2);
        for (int i = 0; i < BL; i++) begin
            logic [7:0] d;
            d = 8'((i * 37 + drop * 11 + 3) & 255);
            xfer(d, i != drop);
            chk("R5 echo", tx_byte, d);
            if (i == drop) begin
                chk("R7 no strobe", st_wr_en, 0);
                chk("R7 to skip", phase, 3);
                break;
            end
            chk("R5 strobe", st_wr_en, 1);
            chk("R5 data", st_wr_data, d);
            n_wr++;
            chk("R6 phase", phase, (i == BL - 1) ? 3 : 2);
        end
        chk("R6 written count", n_wr, (drop < BL) ? drop : BL);
        tail();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 phase", phase, 0); chk("R1 tx", tx_byte, 8'hFF);
        chk("R1 strobe", st_wr_en, 0); chk("R1 index", cmd_index, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2/R3/R4: sweep of every byte value in command mode
        for (int v = 0; v < 256; v++) begin
            xfer(8'(v), 1'b1);
            chk("R2/R3/R4 ans", tx_byte, 8'hFF);
            if (v == 8'hFF) begin
                chk("R2 stays cmd", phase, 0);
            end else if (v == 8'hFE) begin
                chk("R3 write", phase, 2);
                for (int i = 0; i < BL; i++) xfer(8'(i), 1'b1);
                tail();
            end else begin
                chk("R4 arg phase", phase, 1);
                chk("R4 index", cmd_index, v & 63);
                for (int a = 0; a < AL; a++) begin
                    xfer(8'hA5, 1'b1);
                    chk("R4 arg ans", tx_byte, 8'hFF);
                    chk("R4 arg phase", phase, (a == AL - 1) ? 0 : 1);
                end
            end
        end

        // R6/R7: ready withdrawn at every payload position, plus never
        for (int p = 0; p <= BL; p++) block(p);
        block(BL);

        // R10: idle cycles in the middle of a payload
        xfer(8'hFE, 1'b1);
        xfer(8'h3C, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_byte  = 8'h99;
            st_ready = 1'(k & 1);
            chk("R10 phase", phase, 2);
            chk("R10 tx", tx_byte, 8'h3C);
            chk("R10 strobe", st_wr_en, 0);
        end
        for (int i = 1; i < BL; i++) xfer(8'(i), 1'b1);
        chk("R10 count kept", phase, 3);
        tail();
        chk("R10 index kept", cmd_index, 8'hFD & 63);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule